// File: doc/BRIEF.md
# Branch Target Prediction Buffer

This block sits beside an instruction fetch stage and guesses, for each fetch address, whether a conditional branch lives there, whether it will be taken and where it will jump. It is a direct-mapped table. Each slot holds an address tag, the jump destination last seen and a 2-bit saturating confidence counter. The prediction therefore follows the recent behaviour of each branch, not a fixed static rule. Lookups are answered one clock after the request, from registered outputs.

When a branch resolves further down the pipeline, the outcome comes back on the update port. The block compares that outcome with what the table would have predicted for the same address. It trains or allocates the slot, and raises a one-cycle flush request whenever the guess was wrong. The pipeline uses that request to discard the wrongly fetched instructions.

Top module: `btb_predictor`

## Requirements
- R1: After synchronous reset every slot is empty, so every lookup misses; `flush` is low after reset.
- R2: The slot index is address bits [9:2]. The tag is all remaining address bits ([31:10] together with [1:0]). A lookup whose tag differs from the stored tag misses, and a miss returns `lk_taken`=0 and `lk_target`=0.
- R3: Outputs for a lookup presented at a rising edge appear after that edge and hold for one cycle. With `lk_valid` low, `lk_hit` and `lk_taken` are 0.
- R4: On a hit, `lk_taken` is 1 exactly when the slot counter is 2 or 3, and `lk_target` is the stored destination.
- R5: An update for a taken branch that misses allocates the slot: it writes the tag and the destination, sets the counter to 2 and replaces any other branch in that slot. An update for a not-taken branch that misses changes nothing.
- R6: An update that hits moves the counter up by one when the branch was taken and down by one when it was not, saturating at 3 and at 0.
- R7: An update is mispredicted when the predicted direction (counter 2 or 3 on a hit, not taken on a miss) differs from the outcome, or when a taken branch hits with a stored destination unequal to `up_target`. `flush` is then high for exactly the one cycle after that update edge.
- R8: On a mispredicted update that hits, the stored destination is replaced with `up_target`.
- R9: A lookup and an update to the same slot at the same edge return the slot contents from before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Fetch address to look up |
| lk_hit | output | 1 | Registered: a matching slot was found |
| lk_taken | output | 1 | Registered: predicted taken |
| lk_target | output | 32 | Registered: predicted destination (0 on miss) |
| up_valid | input | 1 | Resolved branch update |
| up_addr | input | 32 | Address of the resolved branch |
| up_taken | input | 1 | Resolved direction, 1 = taken |
| up_target | input | 32 | Resolved destination |
| flush | output | 1 | One-cycle misprediction flush request |

## Verification
The bench aims at the counter edges. It drives repeated not-taken outcomes to reach 0 and repeated taken outcomes to reach 3, so a counter that wrapped instead of saturating would flip the prediction and raise a false flush. It aliases two tags onto one slot: a design that compared too few bits would report false hits, and one that failed to replace the slot on a taken miss would keep predicting the old destination. It changes the destination of a taken branch that is already predicted taken, which a design checking direction alone would miss. It also issues a lookup and an update to the same slot at the same edge, where a write-first memory would return the new destination a cycle early.

// File: rtl/btb_pkg.sv
package btb_pkg;
  // What an update does to the slot it addresses
  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_ALLOC = 2'd1,
    ACT_TRAIN = 2'd2
  } upd_act_e;
endpackage

// File: rtl/btb_sat_ctr.sv
module btb_sat_ctr #(
  parameter int CNT_W = 2
) (
  input  logic [CNT_W-1:0] cur,
  input  logic             up,
  output logic [CNT_W-1:0] nxt
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] MINV = '0;

  always_comb begin
    if (up) nxt = (cur == MAXV) ? cur : cur + 1'b1;
    else    nxt = (cur == MINV) ? cur : cur - 1'b1;
  end
endmodule

// File: rtl/btb_resolve.sv
module btb_resolve
  import btb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 24,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              up_valid,
  input  logic [TAG_W-1:0]  up_tag,
  input  logic              up_taken,
  input  logic [ADDR_W-1:0] up_target,
  input  logic              rd_valid,
  input  logic [TAG_W-1:0]  rd_tag,
  input  logic [CNT_W-1:0]  rd_ctr,
  input  logic [ADDR_W-1:0] rd_tgt,
  output upd_act_e          act,
  output logic [CNT_W-1:0]  wr_ctr,
  output logic [ADDR_W-1:0] wr_tgt,
  output logic              mispredict
);
  localparam logic [CNT_W-1:0] ALLOC_V = CNT_W'(1) << (CNT_W - 1);

  logic             hit, pred_t, tgt_bad;
  logic [CNT_W-1:0] trained;

  btb_sat_ctr #(.CNT_W(CNT_W)) u_ctr (.cur(rd_ctr), .up(up_taken), .nxt(trained));

  assign hit        = rd_valid && (rd_tag == up_tag);
  assign pred_t     = hit && rd_ctr[CNT_W-1];
  assign tgt_bad    = up_taken && hit && (rd_tgt != up_target);
  assign mispredict = up_valid && ((pred_t != up_taken) || tgt_bad);

  always_comb begin
    if (!up_valid)     act = ACT_NONE;
    else if (hit)      act = ACT_TRAIN;
    else if (up_taken) act = ACT_ALLOC;
    else               act = ACT_NONE;
    wr_ctr = hit ? trained : ALLOC_V;
    wr_tgt = (hit && !mispredict) ? rd_tgt : up_target;
  end

  // R5: a not-taken miss never allocates
  assert_no_alloc_not_taken_R5: assert property (@(posedge clk) disable iff (rst)
    (up_valid && !hit && !up_taken) |-> (act == ACT_NONE));

  // R6: a taken hit never lowers the counter, a not-taken hit never raises it
  assert_ctr_direction_R6: assert property (@(posedge clk) disable iff (rst)
    (up_valid && hit) |-> (up_taken ? (wr_ctr >= rd_ctr) : (wr_ctr <= rd_ctr)));
endmodule

// File: rtl/btb_store.sv
module btb_store
  import btb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 8,
  parameter int TAG_W  = 24,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [IDX_W-1:0]  lk_idx,
  input  logic [TAG_W-1:0]  lk_tag,
  input  logic [IDX_W-1:0]  up_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [CNT_W-1:0]  rd_ctr,
  output logic [ADDR_W-1:0] rd_tgt,
  input  upd_act_e          act,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [CNT_W-1:0]  wr_ctr,
  input  logic [ADDR_W-1:0] wr_tgt,
  output logic              lk_hit,
  output logic              lk_taken,
  output logic [ADDR_W-1:0] lk_target
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0]  valid_q;
  logic [TAG_W-1:0]  tag_mem [DEPTH];
  logic [CNT_W-1:0]  ctr_mem [DEPTH];
  logic [ADDR_W-1:0] tgt_mem [DEPTH];
  logic              lk_match;

  // update-side read, used to judge the resolved branch
  assign rd_valid = valid_q[up_idx];
  assign rd_tag   = tag_mem[up_idx];
  assign rd_ctr   = ctr_mem[up_idx];
  assign rd_tgt   = tgt_mem[up_idx];

  always_ff @(posedge clk) begin
    if (rst) valid_q <= '0;
    else if (act == ACT_ALLOC) valid_q[up_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (act != ACT_NONE) begin
      tag_mem[up_idx] <= wr_tag;
      ctr_mem[up_idx] <= wr_ctr;
      tgt_mem[up_idx] <= wr_tgt;
    end
  end

  assign lk_match = lk_valid && valid_q[lk_idx] && (tag_mem[lk_idx] == lk_tag);

  // lookup side reads before the write lands: old contents on a collision
  always_ff @(posedge clk) begin
    if (rst) begin
      lk_hit    <= 1'b0;
      lk_taken  <= 1'b0;
      lk_target <= '0;
    end else begin
      lk_hit    <= lk_match;
      lk_taken  <= lk_match && ctr_mem[lk_idx][CNT_W-1];
      lk_target <= lk_match ? tgt_mem[lk_idx] : '0;
    end
  end

  // R1: the cycle after reset nothing can hit
  assert_empty_after_reset_R1: assert property (@(posedge clk)
    $past(rst) |-> !lk_hit);
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
  import btb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 8,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic              lk_taken,
  output logic [ADDR_W-1:0] lk_target,
  input  logic              up_valid,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic              up_taken,
  input  logic [ADDR_W-1:0] up_target,
  output logic              flush
);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int IDX_L = 2;
  localparam int IDX_H = IDX_L + IDX_W - 1;

  logic [IDX_W-1:0]  lk_idx, up_idx;
  logic [TAG_W-1:0]  lk_tag, up_tag, rd_tag;
  logic              rd_valid, mispredict;
  logic [CNT_W-1:0]  rd_ctr, wr_ctr;
  logic [ADDR_W-1:0] rd_tgt, wr_tgt;
  upd_act_e          act;

  assign lk_idx = lk_addr[IDX_H:IDX_L];
  assign up_idx = up_addr[IDX_H:IDX_L];
  assign lk_tag = {lk_addr[ADDR_W-1:IDX_H+1], lk_addr[IDX_L-1:0]};
  assign up_tag = {up_addr[ADDR_W-1:IDX_H+1], up_addr[IDX_L-1:0]};

  btb_store #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_store (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid), .lk_idx(lk_idx), .lk_tag(lk_tag), .up_idx(up_idx),
    .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_ctr(rd_ctr), .rd_tgt(rd_tgt),
    .act(act), .wr_tag(up_tag), .wr_ctr(wr_ctr), .wr_tgt(wr_tgt),
    .lk_hit(lk_hit), .lk_taken(lk_taken), .lk_target(lk_target)
  );

  btb_resolve #(.ADDR_W(ADDR_W), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_resolve (
    .clk(clk), .rst(rst),
    .up_valid(up_valid), .up_tag(up_tag), .up_taken(up_taken), .up_target(up_target),
    .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_ctr(rd_ctr), .rd_tgt(rd_tgt),
    .act(act), .wr_ctr(wr_ctr), .wr_tgt(wr_tgt), .mispredict(mispredict)
  );

  always_ff @(posedge clk) begin
    if (rst) flush <= 1'b0;
    else     flush <= mispredict;
  end

  // R7: a flush only follows an update edge
  assert_flush_after_update_R7: assert property (@(posedge clk) disable iff (rst)
    flush |-> $past(up_valid));

  // R3: a taken prediction always comes with a hit
  assert_taken_implies_hit_R3: assert property (@(posedge clk) disable iff (rst)
    lk_taken |-> lk_hit);

  // R2: a miss carries a zero destination
  assert_miss_zero_target_R2: assert property (@(posedge clk) disable iff (rst)
    !lk_hit |-> (lk_target == '0));
endmodule

// File: tb/btb_predictor_test.sv
module btb_predictor_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        lk_valid, up_valid, up_taken;
  logic [31:0] lk_addr, up_addr, up_target, lk_target;
  logic        lk_hit, lk_taken, flush;

  int checks = 0;
  int errors = 0;

  logic        m_valid [256];
  logic [23:0] m_tag   [256];
  logic [1:0]  m_ctr   [256];
  logic [31:0] m_tgt   [256];

  always #4 clk = ~clk;

  btb_predictor uut (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .lk_hit(lk_hit), .lk_taken(lk_taken), .lk_target(lk_target),
    .up_valid(up_valid), .up_addr(up_addr), .up_taken(up_taken),
    .up_target(up_target), .flush(flush)
  );

  function automatic logic [7:0] f_idx(input logic [31:0] a);
    return a[9:2];
  endfunction
  function automatic logic [23:0] f_tag(input logic [31:0] a);
    return {a[31:10], a[1:0]};
  endfunction

  // one cycle: drive at negedge, compare after the next rising edge
  task automatic step(input logic lv, input logic [31:0] la, input logic uv,
                      input logic [31:0] ua, input logic ut, input logic [31:0] utg,
                      input string rq);
    logic eh, et, ef, hit, pt, mis;
    logic [31:0] etg;
    logic [7:0] li, ui;
    li  = f_idx(la);
    eh  = lv && m_valid[li] && (m_tag[li] == f_tag(la));
    et  = eh && m_ctr[li][1];
    etg = eh ? m_tgt[li] : 32'd0;
    ui  = f_idx(ua);
    hit = m_valid[ui] && (m_tag[ui] == f_tag(ua));
    pt  = hit && m_ctr[ui][1];
    mis = (pt != ut) || (ut && hit && (m_tgt[ui] != utg));
    ef  = uv && mis;
    if (uv) begin
      if (hit) begin
        if (ut) m_ctr[ui] = (m_ctr[ui] == 2'd3) ? 2'd3 : m_ctr[ui] + 2'd1;
        else    m_ctr[ui] = (m_ctr[ui] == 2'd0) ? 2'd0 : m_ctr[ui] - 2'd1;
        if (mis) m_tgt[ui] = utg;
      end else if (ut) begin
        m_valid[ui] = 1'b1;
        m_tag[ui]   = f_tag(ua);
        m_ctr[ui]   = 2'd2;
        m_tgt[ui]   = utg;
      end
    end
    lk_valid = lv; lk_addr = la; up_valid = uv; up_addr = ua;
    up_taken = ut; up_target = utg;
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (lk_hit !== eh || lk_taken !== et || lk_target !== etg || flush !== ef) begin
      errors++;
      $display("FAIL %s: got hit=%0b taken=%0b tgt=%h flush=%0b, expected hit=%0b taken=%0b tgt=%h flush=%0b",
               rq, lk_hit, lk_taken, lk_target, flush, eh, et, etg, ef);
    end
  endtask

  task automatic look(input logic [31:0] a, input string rq);
    step(1'b1, a, 1'b0, 32'd0, 1'b0, 32'd0, rq);
  endtask
  task automatic upd(input logic [31:0] a, input logic t, input logic [31:0] g, input string rq);
    step(1'b0, 32'd0, 1'b1, a, t, g, rq);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  localparam logic [31:0] A = 32'h0000_1040; // slot 0x10
  localparam logic [31:0] B = 32'h0000_2080; // slot 0x20
  localparam logic [31:0] C = 32'h0000_5040; // slot 0x10, other tag

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) begin
      m_valid[i] = 1'b0; m_tag[i] = '0; m_ctr[i] = '0; m_tgt[i] = '0;
    end
    rst = 1'b1; lk_valid = 0; lk_addr = 0; up_valid = 0; up_addr = 0;
    up_taken = 0; up_target = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    look(A, "R1 lookup after reset");
    look(B, "R1 second slot empty");
    upd(A, 1'b1, 32'h0000_9000, "R7 taken miss flushes / R5 allocate");
    look(A, "R5 allocated slot predicts taken R4");
    step(1'b0, A, 1'b0, 32'd0, 1'b0, 32'd0, "R3 no lookup no hit");
    upd(B, 1'b0, 32'h0000_7000, "R5 not-taken miss no flush");
    look(B, "R5 not-taken miss not allocated");
    look(C, "R2 aliased tag misses");
    upd(A, 1'b0, 32'h0000_1044, "R7 direction wrong flushes");
    look(A, "R8 target replaced, R4 counter 1 not taken");
    for (int k = 0; k < 3; k++) upd(A, 1'b0, 32'h0000_1044, "R6 down to 0");
    look(A, "R6 floor holds");
    upd(A, 1'b1, 32'h0000_9000, "R6 from 0 still mispredicts");
    upd(A, 1'b1, 32'h0000_9000, "R6 counter 1 to 2 flush");
    for (int k = 0; k < 4; k++) upd(A, 1'b1, 32'h0000_9000, "R6 up to 3");
    upd(A, 1'b0, 32'h0000_9000, "R6 from 3 not taken still predicted taken");
    look(A, "R6 counter 2 predicts taken");
    upd(A, 1'b1, 32'h0000_A000, "R7 target change flushes");
    look(A, "R8 new target");
    step(1'b1, A, 1'b1, A, 1'b1, 32'h0000_B000, "R9 same-edge lookup sees old");
    look(A, "R9 update visible next cycle");
    upd(C, 1'b1, 32'h0000_C000, "R5 taken miss replaces alias");
    look(A, "R5 old branch evicted");
    look(C, "R5 new branch present");
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] la, ua, tg;
      la = {20'd0, 2'($urandom_range(0, 2)), 2'd0, 6'($urandom_range(0, 3)), 2'd0};
      ua = {20'd0, 2'($urandom_range(0, 2)), 2'd0, 6'($urandom_range(0, 3)), 2'd0};
      tg = 32'h100 * $urandom_range(1, 3);
      step(1'($urandom), la, 1'($urandom), ua, 1'($urandom), tg, "R4 random R7");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule